// File: doc/BRIEF.md
# Multi-Channel Timer Interrupt Unit

This block holds five independent down-counters. Each counter has a run bit, a count register, a reload constant and a control register. A counter that is running steps down by one every clock. When it is at zero it does not step below zero. Instead it loads its reload constant and raises its underflow flag in that same cycle. A counter therefore repeats every reload+1 cycles. Each channel drives its own underflow interrupt line. The line is high while that channel's flag and enable are both set.

Channel 2 also has a capture function fed by an external input. On a rising edge of that input, with capture switched on, the present channel 2 count is copied into a capture register and a capture flag is set. The capture interrupt line needs the flag and also needs both bits of the two-bit capture control field to be set. Software reaches every register through a plain single-cycle write port and a combinational read port. It may start and stop channels at any time. It may clear flags while a channel runs, provided the same write carries the current values of the other control bits.

Top module: `tmr_irq_unit`

## Requirements
- R1: A running channel's count drops by exactly one on each clock while it is non-zero. A stopped channel's count does not change unless software writes it.
- R2: When a running channel's count is 0, the next clock loads the reload constant into the count and sets the underflow flag. With start value S and reload L, the count after n running clocks is S-n for n<=S and L-((n-S-1) mod (L+1)) otherwise.
- R3: Bit n of the start register (address 0x1C) runs channel n. The register can be written and read back at any time, including while channels are running.
- R4: Control bit 1 is the underflow flag and channel 2 control bit 4 is the capture flag. Writing 0 to a flag bit clears it, and writing 1 has no effect. If hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R5: A control write that clears a flag and carries the current enable (bit 0) leaves the enable unchanged and does not disturb the running count.
- R6: Underflow interrupt line n is high exactly while channel n's underflow flag and enable bit (control bit 0) are both 1. Each channel is gated independently.
- R7: When channel 2 control bit 3 is 1, a rising edge of the capture input copies the channel 2 count (as it stands just before that clock) into the capture register (address 0x1D) and sets the capture flag. When bit 3 is 0, edges are ignored.
- R8: The capture interrupt is high only while the capture flag is 1 and the capture control field (channel 2 control bits 3:2) equals 11. With any other value of the field the capture interrupt is low.
- R9: After reset every count, start bit, flag, enable and capture control field is 0, the capture register is 0, and every reload constant reads all ones.
- R10: Register address = {channel[2:0], select[1:0]}, where select 0 is the count, 1 is the reload constant and 2 is control. Channel field 7 selects the global registers: select 0 is start and select 1 is capture. A write reaches only the addressed register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Combinational read data for bus_addr |
| cap_in | input | 1 | External capture input, synchronous to clk |
| irq_unf | output | NUM_CH | Per-channel underflow interrupt requests, level |
| irq_cap | output | 1 | Capture interrupt request, level |

## Verification
The assertions assume that cap_in is already synchronous to clk and that the count register is not written in the same cycle the reload checks look at. The reload assertion is therefore gated by the count write strobe. The bench changes count, reload and enable values only while every channel is stopped. While channels run, it writes only the start register and flag-clearing control words that carry the current enable and capture-control values. It drives cap_in and every bus input on the falling edge, so each edge event falls on a known count value.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  // register select inside a channel's address window
  typedef enum logic [1:0] {
    SEL_COUNT  = 2'd0,
    SEL_RELOAD = 2'd1,
    SEL_CTRL   = 2'd2,
    SEL_SPARE  = 2'd3
  } tmr_sel_e;

  // global window selects
  localparam logic [1:0] GSEL_START   = 2'd0;
  localparam logic [1:0] GSEL_CAPTURE = 2'd1;

  // control word layout
  localparam int unsigned CTL_IE_BIT  = 0;
  localparam int unsigned CTL_UF_BIT  = 1;
  localparam int unsigned CTL_CPC_LSB = 2;
  localparam int unsigned CTL_CF_BIT  = 4;
  localparam int unsigned CTL_W       = 5;

  // capture control value that lets the capture interrupt through
  localparam logic [1:0] CPC_IRQ_ON = 2'b11;
endpackage

// File: rtl/tmr_channel.sv
`timescale 1ns/1ps
module tmr_channel
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             cnt_we,
  input  logic             reload_we,
  input  logic             ctl_we,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] reload_q,
  output logic             ie_q,
  output logic             uf_q,
  output logic             unf_evt
);

  // next count of a running channel
  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] cur,
                                                  input logic [CNT_W-1:0] rld);
    if (cur == '0) return rld;
    return cur - CNT_W'(1);
  endfunction

  logic uf_clr_req;

  assign unf_evt    = run && (cnt_q == '0);
  assign uf_clr_req = ctl_we && !wdata[CTL_UF_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      reload_q <= '1;
      ie_q     <= 1'b0;
      uf_q     <= 1'b0;
    end else begin
      if (cnt_we)      cnt_q <= wdata;
      else if (run)    cnt_q <= step_count(cnt_q, reload_q);
      if (reload_we)   reload_q <= wdata;
      if (ctl_we)      ie_q <= wdata[CTL_IE_BIT];
      if (unf_evt)         uf_q <= 1'b1;   // hardware set wins
      else if (uf_clr_req) uf_q <= 1'b0;
    end
  end

  p_step_down_r1: assert property (@(posedge clk) disable iff (!rst_n)
    run && !cnt_we && (cnt_q != '0) |=> cnt_q == $past(cnt_q) - CNT_W'(1));

  p_hold_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !cnt_we |=> $stable(cnt_q));

  p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt && !cnt_we && !reload_we |=> cnt_q == $past(reload_q));

  p_flag_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unf_evt |=> uf_q);

  p_flag_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    uf_q && !uf_clr_req |=> uf_q);

  p_flag_no_spont_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !uf_q && !unf_evt |=> !uf_q);

  p_enable_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ie_q));

endmodule

// File: rtl/tmr_capture.sv
`timescale 1ns/1ps
module tmr_capture
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_in,
  input  logic             ctl_we,
  input  logic [1:0]       cpc_wd,
  input  logic             cf_wd,
  input  logic [CNT_W-1:0] cnt_in,
  output logic [CNT_W-1:0] cap_q,
  output logic [1:0]       cpc_q,
  output logic             cf_q,
  output logic             cap_evt
);

  // capture is armed whenever the upper control bit is set
  function automatic logic cap_armed(input logic [1:0] cpc);
    return cpc[1];
  endfunction

  logic cap_in_q;
  logic cap_rise;
  logic cf_clr_req;

  assign cap_rise   = cap_in && !cap_in_q;
  assign cap_evt    = cap_rise && cap_armed(cpc_q);
  assign cf_clr_req = ctl_we && !cf_wd;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_in_q <= 1'b0;
      cap_q    <= '0;
      cpc_q    <= '0;
      cf_q     <= 1'b0;
    end else begin
      cap_in_q <= cap_in;
      if (cap_evt) cap_q <= cnt_in;
      if (ctl_we)  cpc_q <= cpc_wd;
      if (cap_evt)         cf_q <= 1'b1;
      else if (cf_clr_req) cf_q <= 1'b0;
    end
  end

  p_cap_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt_in)) && cf_q);

  p_cap_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpc_q[1] |=> $stable(cap_q));

  p_cf_no_spont_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cf_q && !cap_evt |=> !cf_q);

  p_cf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cf_q && !cf_clr_req |=> cf_q);

endmodule

// File: rtl/tmr_irq_gate.sv
`timescale 1ns/1ps
module tmr_irq_gate
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 5
) (
  input  logic [NUM_CH-1:0] uf,
  input  logic [NUM_CH-1:0] ie,
  input  logic              cf,
  input  logic [1:0]        cpc,
  output logic [NUM_CH-1:0] irq_unf,
  output logic              irq_cap
);

  function automatic logic unf_req(input logic flag, input logic en);
    return flag & en;
  endfunction

  function automatic logic cap_req(input logic flag, input logic [1:0] ctl);
    return flag && (ctl == CPC_IRQ_ON);
  endfunction

  for (genvar g = 0; g < NUM_CH; g++) begin : g_line
    assign irq_unf[g] = unf_req(uf[g], ie[g]);
  end

  assign irq_cap = cap_req(cf, cpc);

endmodule

// File: rtl/tmr_irq_unit.sv
`timescale 1ns/1ps
module tmr_irq_unit
  import tmr_pkg::*;
#(
  parameter int unsigned NUM_CH = 5,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned CAP_CH = 2,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  input  logic              cap_in,
  output logic [NUM_CH-1:0] irq_unf,
  output logic              irq_cap
);

  localparam int unsigned    CH_W      = ADDR_W - 2;
  localparam logic [CH_W-1:0] GLOBAL_ID = '1;

  logic [CH_W-1:0] a_ch;
  logic [1:0]      a_sel;
  logic            global_hit;
  logic            start_we;

  assign a_ch       = bus_addr[ADDR_W-1:2];
  assign a_sel      = bus_addr[1:0];
  assign global_hit = (a_ch == GLOBAL_ID);
  assign start_we   = bus_we && global_hit && (a_sel == GSEL_START);

  logic [NUM_CH-1:0] start_q;

  always_ff @(posedge clk) begin
    if (!rst_n) start_q <= '0;
    else if (start_we) start_q <= bus_wdata[NUM_CH-1:0];
  end

  logic [CNT_W-1:0] cnt_arr    [NUM_CH];
  logic [CNT_W-1:0] reload_arr [NUM_CH];
  logic [CTL_W-1:0] ctl_arr    [NUM_CH];
  logic [NUM_CH-1:0] uf_vec, ie_vec, unf_evt_vec, ctl_we_vec;

  logic [CNT_W-1:0] cap_q;
  logic [1:0]       cpc_q;
  logic             cf_q;
  logic             cap_evt;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    logic hit;
    assign hit           = bus_we && (a_ch == CH_W'(g));
    assign ctl_we_vec[g] = hit && (a_sel == SEL_CTRL);

    tmr_channel #(.CNT_W(CNT_W)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (start_q[g]),
      .cnt_we    (hit && (a_sel == SEL_COUNT)),
      .reload_we (hit && (a_sel == SEL_RELOAD)),
      .ctl_we    (ctl_we_vec[g]),
      .wdata     (bus_wdata),
      .cnt_q     (cnt_arr[g]),
      .reload_q  (reload_arr[g]),
      .ie_q      (ie_vec[g]),
      .uf_q      (uf_vec[g]),
      .unf_evt   (unf_evt_vec[g])
    );

    if (g == CAP_CH) begin : g_capfields
      assign ctl_arr[g] = {cf_q, cpc_q, uf_vec[g], ie_vec[g]};
    end else begin : g_plain
      assign ctl_arr[g] = {3'b000, uf_vec[g], ie_vec[g]};
    end

    p_unf_line_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
      uf_vec[g] && ie_vec[g] |-> irq_unf[g]);
    p_unf_line_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !uf_vec[g] || !ie_vec[g] |-> !irq_unf[g]);
    p_start_gates_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !start_q[g] |-> !unf_evt_vec[g]);
  end

  tmr_capture #(.CNT_W(CNT_W)) u_cap (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_in  (cap_in),
    .ctl_we  (ctl_we_vec[CAP_CH]),
    .cpc_wd  (bus_wdata[CTL_CPC_LSB +: 2]),
    .cf_wd   (bus_wdata[CTL_CF_BIT]),
    .cnt_in  (cnt_arr[CAP_CH]),
    .cap_q   (cap_q),
    .cpc_q   (cpc_q),
    .cf_q    (cf_q),
    .cap_evt (cap_evt)
  );

  tmr_irq_gate #(.NUM_CH(NUM_CH)) u_gate (
    .uf      (uf_vec),
    .ie      (ie_vec),
    .cf      (cf_q),
    .cpc     (cpc_q),
    .irq_unf (irq_unf),
    .irq_cap (irq_cap)
  );

  // combinational read path
  always_comb begin
    bus_rdata = '0;
    if (global_hit) begin
      case (a_sel)
        GSEL_START:   bus_rdata = CNT_W'(start_q);
        GSEL_CAPTURE: bus_rdata = cap_q;
        default:      bus_rdata = '0;
      endcase
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (a_ch == CH_W'(i)) begin
          case (a_sel)
            SEL_COUNT:  bus_rdata = cnt_arr[i];
            SEL_RELOAD: bus_rdata = reload_arr[i];
            SEL_CTRL:   bus_rdata = CNT_W'(ctl_arr[i]);
            default:    bus_rdata = '0;
          endcase
        end
      end
    end
  end

  p_start_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_we |=> start_q == $past(bus_wdata[NUM_CH-1:0]));

  p_cap_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_cap |-> cf_q && (cpc_q == CPC_IRQ_ON));

  p_cap_line_on_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cf_q && (cpc_q == CPC_IRQ_ON) |-> irq_cap);

endmodule

// File: tb/tb_tmr_irq_unit.sv
`timescale 1ns/100ps
module tb_tmr_irq_unit;
  localparam int NCH = 5;
  localparam logic [4:0] A_START = 5'h1C;
  localparam logic [4:0] A_CAP   = 5'h1D;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cap_in = 1'b0;
  logic [NCH-1:0] irq_unf;
  logic        irq_cap;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_irq_unit dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cap_in(cap_in),
    .irq_unf(irq_unf), .irq_cap(irq_cap)
  );

  function automatic logic [4:0] ad(input int ch, input int sel);
    return {ch[2:0], sel[1:0]};
  endfunction

  // count after n running clocks from start s with reload l
  function automatic logic [31:0] exp_count(input int s, input int l, input int n);
    if (n <= s) return 32'(s - n);
    return 32'(l - ((n - s - 1) % (l + 1)));
  endfunction

  function automatic logic exp_flag(input int s, input int n);
    return n > s;
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    bus_addr = a;
    #0.4;
    v = bus_rdata;
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #80000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9 reset state
    for (int c = 0; c < NCH; c++) begin
      rd(ad(c, 0), v); check("R9", "count", v, 0);
      rd(ad(c, 1), v); check("R9", "reload", v, 32'hFFFF_FFFF);
      rd(ad(c, 2), v); check("R9", "ctl", v, 0);
      @(negedge clk);
    end
    rd(A_START, v); check("R9", "start", v, 0);
    rd(A_CAP, v);   check("R9", "capture", v, 0);
    check("R9", "irq lines", {26'd0, irq_cap, irq_unf}, 0);

    // R1 hold while stopped, R10 address decode
    wr(ad(0, 0), 5);
    wr(ad(0, 1), 7);
    repeat (6) @(negedge clk);
    rd(ad(0, 0), v); check("R1", "stopped count", v, 5);
    rd(ad(0, 1), v); check("R10", "ch0 reload", v, 7);
    rd(ad(1, 1), v); check("R10", "ch1 reload untouched", v, 32'hFFFF_FFFF);

    // R2 / R6 on ch0 (enabled) and ch1 (zero reload, disabled)
    wr(ad(0, 2), 32'h1);
    wr(ad(1, 0), 0);
    wr(ad(1, 1), 0);
    wr(A_START, 32'h03);
    rd(ad(0, 0), v); check("R1", "ch0 at step 0", v, 5);
    repeat (5) @(negedge clk);
    rd(ad(0, 0), v); check("R1", "ch0 at step 5", v, 0);
    check("R6", "irq0 before underflow", irq_unf[0], 0);
    @(negedge clk);
    rd(ad(0, 0), v); check("R2", "ch0 reloaded", v, 7);
    rd(ad(0, 2), v); check("R2", "ch0 flag+ie", v, 3);
    rd(ad(1, 2), v); check("R2", "ch1 flag", v, 2);
    check("R6", "irq0 high", irq_unf[0], 1);
    check("R6", "irq1 low, ie=0", irq_unf[1], 0);

    // R4 set wins over clear (ch1 underflows every clock)
    wr(ad(1, 2), 0);
    rd(ad(1, 2), v); check("R4", "set beats clear", v, 2);
    wr(A_START, 0);
    wr(ad(1, 2), 0);
    rd(ad(1, 2), v); check("R4", "clear while stopped", v, 0);
    wr(ad(1, 2), 32'h2);
    rd(ad(1, 2), v); check("R4", "write 1 no effect", v, 0);
    wr(ad(0, 2), 0);
    check("R6", "irq0 drops with flag", irq_unf[0], 0);

    // R5 / R3 clear while running on ch3
    wr(ad(3, 0), 1);
    wr(ad(3, 1), 50);
    wr(ad(3, 2), 1);
    wr(A_START, 32'h08);
    rd(A_START, v); check("R3", "start readback", v, 32'h08);
    repeat (3) @(negedge clk);
    rd(ad(3, 2), v); check("R5", "ch3 flag set", v, 3);
    check("R6", "irq3 high", irq_unf[3], 1);
    wr(ad(3, 2), 1);
    rd(ad(3, 0), v); check("R5", "count undisturbed", v, exp_count(1, 50, 5));
    rd(ad(3, 2), v); check("R5", "enable kept", v, 1);
    check("R6", "irq3 cleared", irq_unf[3], 0);
    wr(A_START, 0);
    rd(A_START, v); check("R3", "start cleared", v, 0);

    // R7 / R8 capture on ch2, stopped
    wr(ad(2, 0), 100);
    wr(ad(2, 2), 32'hC);
    @(negedge clk); cap_in = 1'b1;
    @(negedge clk);
    rd(A_CAP, v);    check("R7", "captured value", v, 100);
    rd(ad(2, 2), v); check("R7", "cf and cpc", v, 32'h1C);
    check("R8", "irq_cap high at 11", irq_cap, 1);
    wr(ad(2, 2), 32'h18);
    rd(ad(2, 2), v); check("R8", "cf kept at 10", v, 32'h18);
    check("R8", "irq_cap low at 10", irq_cap, 0);
    wr(ad(2, 2), 32'h4);
    cap_in = 1'b0;
    wr(ad(2, 0), 33);
    cap_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rd(A_CAP, v);    check("R7", "no capture when off", v, 100);
    rd(ad(2, 2), v); check("R7", "cf stays clear", v, 32'h4);
    check("R8", "irq_cap low at 01", irq_cap, 0);
    cap_in = 1'b0;
    // capture while running
    wr(ad(2, 2), 32'hC);
    wr(ad(2, 0), 500);
    wr(ad(2, 1), 500);
    wr(A_START, 32'h04);
    repeat (2) @(negedge clk);
    cap_in = 1'b1;
    @(negedge clk);
    rd(A_CAP, v); check("R7", "running capture", v, exp_count(500, 500, 2));
    check("R8", "irq_cap running", irq_cap, 1);
    wr(ad(2, 2), 32'hC);
    check("R8", "irq_cap after clear", irq_cap, 0);
    wr(A_START, 0);
    cap_in = 1'b0;

    // random trials: R1, R2, R6
    for (int t = 0; t < 8; t++) begin
      int s0 [NCH];
      int l0 [NCH];
      logic ie [NCH];
      logic [NCH-1:0] mask;
      int j0;
      wr(A_START, 0);
      for (int c = 0; c < NCH; c++) begin
        s0[c] = $urandom_range(0, 40);
        l0[c] = $urandom_range(0, 12);
        ie[c] = 1'($urandom_range(0, 1));
        wr(ad(c, 0), 32'(s0[c]));
        wr(ad(c, 1), 32'(l0[c]));
        wr(ad(c, 2), {31'd0, ie[c]});
      end
      mask = 5'($urandom_range(1, 31));
      j0 = $urandom_range(0, 60);
      wr(A_START, {27'd0, mask});
      repeat (j0) @(negedge clk);
      for (int c = 0; c < NCH; c++) begin
        int n;
        logic [31:0] ec;
        logic ef;
        n  = j0 + c;
        ec = mask[c] ? exp_count(s0[c], l0[c], n) : 32'(s0[c]);
        ef = mask[c] ? exp_flag(s0[c], n) : 1'b0;
        rd(ad(c, 0), v); check(mask[c] ? "R2" : "R1", "random count", v, ec);
        rd(ad(c, 2), v); check("R2", "random flag", {31'd0, v[1]}, {31'd0, ef});
        check("R6", "random irq", {31'd0, irq_unf[c]}, {31'd0, ef & ie[c]});
        @(negedge clk);
      end
    end

    report();
  end
endmodule